// File: doc/BRIEF.md
# Coherence Sharer Directory with Overflow Threshold

This block keeps, for every line of a shared memory cache, a record of which private L1 caches hold a copy. It also decides which coherence action a write or a victim replacement needs. Each line's record is a small table of sharer slots. A slot holds the source identifier of an L1 cache and one bit that says whether the copy sits in an instruction cache or a data cache. When one processor holds a line in both its caches, that takes two slots.

While the number of copies stays at or below a threshold, the record is an exact list. A write then produces a targeted update to every listed copy except the writer's data copy, and an eviction produces a targeted invalidate. Once the copies exceed the threshold, the list is dropped and only a count is kept. From then on a write or an eviction can only be served by a broadcast invalidate.

Requests arrive one per cycle and carry an operation, a line index, a source id and a copy type. Each request produces one registered result that carries:
- an action code,
- a target mask over the slots,
- the slot contents,
- a count.

The record store is a synchronous-read RAM. The result of the request just before is forwarded, so back-to-back requests to the same line see each other's effects.

Top module: `coh_directory`

## Requirements
- R1: After reset every line is empty and in list mode. act_valid is 0, and the first eviction of any line yields action NONE (code 0) with a zero mask and a zero count.
- R2: Each accepted request (req_valid high at a rising edge) produces act_valid high for exactly one cycle, visible after the second rising edge. When act_valid is low, act_code is NONE. Operation codes are: 0 register, 1 cleanup, 2 write, 3 evict. Action codes are: 0 NONE, 1 MULTI_UPDATE, 2 MULTI_INVAL, 3 BROADCAST_INVAL.
- R3: A register request places the (source, type) pair in the lowest-numbered free slot. Slot i appears in act_src bits [i*SRC_W +: SRC_W] and act_ins bit i (1 = instruction). The same source with a different type takes a separate slot.
- R4: A register request that matches an existing slot in both source and type has no effect on the record.
- R5: A register request that would make the copy count exceed THRESH discards the list and switches the line to counter mode, with count THRESH+1. Further register requests increment the count.
- R6: A write to a line in list mode yields MULTI_UPDATE with act_mask set for every occupied slot, except a data-type slot whose source equals the writer. act_count is the number of targets. If no targets remain, the result is NONE. A write leaves a list-mode record unchanged.
- R7: An eviction of a list-mode line with copies yields MULTI_INVAL, with every occupied slot in the mask and act_count equal to the number of copies. The line is then empty.
- R8: A write to, or an eviction of, a counter-mode line yields BROADCAST_INVAL, with act_count equal to the copy count and a zero mask. The line is then empty and in list mode.
- R9: A cleanup in list mode frees only the slot that matches both source and type. A cleanup that matches no slot has no effect.
- R10: A cleanup in counter mode decrements the count, and the line stays in counter mode. When the last copy is removed, the line returns to empty list mode.
- R11: Requests to the same line on consecutive cycles each see the record left by the request before.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Request strobe |
| req_op | input | 2 | Operation: 0 register, 1 cleanup, 2 write, 3 evict |
| req_line | input | LINE_W | Line index |
| req_src | input | SRC_W | Source id of the requesting L1 cache |
| req_ins | input | 1 | Copy type: 1 instruction, 0 data |
| act_valid | output | 1 | Result strobe |
| act_code | output | 2 | Action code |
| act_mask | output | THRESH | Slots that are targets of the action |
| act_src | output | THRESH*SRC_W | Source id held in each slot |
| act_ins | output | THRESH | Copy type held in each slot |
| act_count | output | SRC_W+2 | Number of targets, or copy count for a broadcast |

## Verification
The hardest states to reach are a counter-mode line whose count has been brought back down by cleanups. There are two cases: one where the count settles at or below the threshold but the line stays in counter mode, and one where the count reaches zero and the line falls back to list mode. The stimulus fills a line past the threshold, then issues a measured run of cleanups. A following write or a fresh register-and-evict then shows at the ports which mode the line is in. Forwarding between pipeline stages can only be exercised by consecutive-cycle requests to the same line, so one scenario issues three such requests with no gap and checks the last result.

// File: rtl/coh_dir_pkg.sv
package coh_dir_pkg;
  typedef enum logic [1:0] {
    OP_REG   = 2'd0,
    OP_CLEAN = 2'd1,
    OP_WRITE = 2'd2,
    OP_EVICT = 2'd3
  } op_e;

  typedef enum logic [1:0] {
    ACT_NONE  = 2'd0,
    ACT_MUPD  = 2'd1,
    ACT_MINV  = 2'd2,
    ACT_BCAST = 2'd3
  } act_e;
endpackage

// File: rtl/coh_dir_ram.sv
module coh_dir_ram #(
  parameter int WIDTH  = 32,
  parameter int ADDR_W = 4
) (
  input  logic              clk,
  input  logic              we,
  input  logic [ADDR_W-1:0] waddr,
  input  logic [WIDTH-1:0]  wdata,
  input  logic [ADDR_W-1:0] raddr,
  output logic [WIDTH-1:0]  rdata
);
  localparam int DEPTH = 1 << ADDR_W;

  logic [WIDTH-1:0] mem [DEPTH];

  // simple dual port, read-first: suits block RAM inference
  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
    rdata <= mem[raddr];
  end
endmodule

// File: rtl/coh_dir_update.sv
module coh_dir_update
  import coh_dir_pkg::*;
#(
  parameter int SRC_W  = 4,
  parameter int THRESH = 4,
  parameter int CNT_W  = 6
) (
  input  logic [1:0]              op,
  input  logic [SRC_W-1:0]        src,
  input  logic                    ins,
  input  logic                    cur_mode,
  input  logic [CNT_W-1:0]        cur_count,
  input  logic [THRESH-1:0]       cur_vld,
  input  logic [THRESH-1:0]       cur_ins,
  input  logic [THRESH*SRC_W-1:0] cur_src,
  output logic                    nxt_mode,
  output logic [CNT_W-1:0]        nxt_count,
  output logic [THRESH-1:0]       nxt_vld,
  output logic [THRESH-1:0]       nxt_ins,
  output logic [THRESH*SRC_W-1:0] nxt_src,
  output logic [1:0]              code,
  output logic [THRESH-1:0]       mask,
  output logic [CNT_W-1:0]        count_out
);
  localparam logic [CNT_W-1:0] THR_C  = CNT_W'(THRESH);
  localparam logic [CNT_W-1:0] OVF_C  = CNT_W'(THRESH + 1);
  localparam logic [CNT_W-1:0] ONE_C  = CNT_W'(1);
  localparam logic [CNT_W-1:0] CMAX_C = {CNT_W{1'b1}};

  logic [THRESH-1:0] match;
  logic [THRESH-1:0] wr_tgt;
  logic [THRESH-1:0] free_oh;

  // lowest empty slot as a one-hot vector
  assign free_oh = ~cur_vld & (cur_vld + THRESH'(1));

  for (genvar i = 0; i < THRESH; i++) begin : g_slot
    logic same_src;
    assign same_src  = cur_src[i*SRC_W +: SRC_W] == src;
    assign match[i]  = cur_vld[i] && same_src && (cur_ins[i] == ins);
    assign wr_tgt[i] = cur_vld[i] && !(same_src && !cur_ins[i]);
  end

  always_comb begin
    nxt_mode  = cur_mode;
    nxt_count = cur_count;
    nxt_vld   = cur_vld;
    nxt_ins   = cur_ins;
    nxt_src   = cur_src;
    code      = ACT_NONE;
    mask      = '0;
    count_out = '0;
    unique case (op_e'(op))
      OP_REG: begin
        if (cur_mode) begin
          if (cur_count != CMAX_C) nxt_count = cur_count + ONE_C;
        end else if (match == '0) begin
          if (cur_count < THR_C) begin
            nxt_vld   = cur_vld | free_oh;
            nxt_count = cur_count + ONE_C;
            for (int i = 0; i < THRESH; i++) begin
              if (free_oh[i]) begin
                nxt_src[i*SRC_W +: SRC_W] = src;
                nxt_ins[i]                = ins;
              end
            end
          end else begin
            nxt_mode  = 1'b1;
            nxt_count = OVF_C;
            nxt_vld   = '0;
            nxt_ins   = '0;
            nxt_src   = '0;
          end
        end
      end
      OP_CLEAN: begin
        if (cur_mode) begin
          if (cur_count <= ONE_C) begin
            nxt_mode  = 1'b0;
            nxt_count = '0;
          end else begin
            nxt_count = cur_count - ONE_C;
          end
        end else if (match != '0) begin
          nxt_vld   = cur_vld & ~match;
          nxt_count = cur_count - ONE_C;
        end
      end
      OP_WRITE: begin
        if (cur_mode) begin
          code      = ACT_BCAST;
          count_out = cur_count;
          nxt_mode  = 1'b0;
          nxt_count = '0;
          nxt_vld   = '0;
          nxt_ins   = '0;
          nxt_src   = '0;
        end else if (wr_tgt != '0) begin
          code      = ACT_MUPD;
          mask      = wr_tgt;
          count_out = CNT_W'($countones(wr_tgt));
        end
      end
      default: begin
        if (cur_mode) begin
          code      = ACT_BCAST;
          count_out = cur_count;
        end else if (cur_vld != '0) begin
          code      = ACT_MINV;
          mask      = cur_vld;
          count_out = cur_count;
        end
        nxt_mode  = 1'b0;
        nxt_count = '0;
        nxt_vld   = '0;
        nxt_ins   = '0;
        nxt_src   = '0;
      end
    endcase
  end
endmodule

// File: rtl/coh_directory.sv
module coh_directory
  import coh_dir_pkg::*;
#(
  parameter int LINE_W = 4,
  parameter int SRC_W  = 4,
  parameter int THRESH = 4
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic                    req_valid,
  input  logic [1:0]              req_op,
  input  logic [LINE_W-1:0]       req_line,
  input  logic [SRC_W-1:0]        req_src,
  input  logic                    req_ins,
  output logic                    act_valid,
  output logic [1:0]              act_code,
  output logic [THRESH-1:0]       act_mask,
  output logic [THRESH*SRC_W-1:0] act_src,
  output logic [THRESH-1:0]       act_ins,
  output logic [SRC_W+1:0]        act_count
);
  localparam int CNT_W  = SRC_W + 2;
  localparam int NLINES = 1 << LINE_W;
  localparam int REC_W  = 1 + CNT_W + 2*THRESH + THRESH*SRC_W;

  // record layout: {mode, count, vld, ins, src}
  logic [REC_W-1:0] rd_rec, cur_rec, nxt_rec, wb_rec;

  logic              s1_valid, s1_live;
  logic [1:0]        s1_op;
  logic [LINE_W-1:0] s1_line, wb_line;
  logic [SRC_W-1:0]  s1_src;
  logic              s1_ins, wb_valid;
  logic [NLINES-1:0] line_live;

  logic                    cur_mode, nxt_mode;
  logic [CNT_W-1:0]        cur_count, nxt_count, u_count;
  logic [THRESH-1:0]       cur_vld, cur_ins, nxt_vld, nxt_ins, u_mask;
  logic [THRESH*SRC_W-1:0] cur_src, nxt_src;
  logic [1:0]              u_code;

  coh_dir_ram #(.WIDTH(REC_W), .ADDR_W(LINE_W)) u_ram (
    .clk   (clk),
    .we    (s1_valid),
    .waddr (s1_line),
    .wdata (nxt_rec),
    .raddr (req_line),
    .rdata (rd_rec)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      s1_valid  <= 1'b0;
      s1_live   <= 1'b0;
      s1_op     <= '0;
      s1_line   <= '0;
      s1_src    <= '0;
      s1_ins    <= 1'b0;
      line_live <= '0;
      wb_valid  <= 1'b0;
      wb_line   <= '0;
      wb_rec    <= '0;
    end else begin
      s1_valid <= req_valid;
      s1_live  <= line_live[req_line];
      s1_op    <= req_op;
      s1_line  <= req_line;
      s1_src   <= req_src;
      s1_ins   <= req_ins;
      wb_valid <= s1_valid;
      wb_line  <= s1_line;
      wb_rec   <= nxt_rec;
      if (s1_valid) line_live[s1_line] <= 1'b1;
    end
  end

  // forward the record written on the previous edge, which the RAM read missed
  always_comb begin
    if (wb_valid && wb_line == s1_line) cur_rec = wb_rec;
    else if (s1_live)                   cur_rec = rd_rec;
    else                                cur_rec = '0;
  end

  assign {cur_mode, cur_count, cur_vld, cur_ins, cur_src} = cur_rec;
  assign nxt_rec = {nxt_mode, nxt_count, nxt_vld, nxt_ins, nxt_src};

  coh_dir_update #(.SRC_W(SRC_W), .THRESH(THRESH), .CNT_W(CNT_W)) u_upd (
    .op        (s1_op),
    .src       (s1_src),
    .ins       (s1_ins),
    .cur_mode  (cur_mode),
    .cur_count (cur_count),
    .cur_vld   (cur_vld),
    .cur_ins   (cur_ins),
    .cur_src   (cur_src),
    .nxt_mode  (nxt_mode),
    .nxt_count (nxt_count),
    .nxt_vld   (nxt_vld),
    .nxt_ins   (nxt_ins),
    .nxt_src   (nxt_src),
    .code      (u_code),
    .mask      (u_mask),
    .count_out (u_count)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      act_valid <= 1'b0;
      act_code  <= ACT_NONE;
      act_mask  <= '0;
      act_src   <= '0;
      act_ins   <= '0;
      act_count <= '0;
    end else begin
      act_valid <= s1_valid;
      act_code  <= s1_valid ? u_code  : ACT_NONE;
      act_mask  <= s1_valid ? u_mask  : '0;
      act_src   <= s1_valid ? cur_src : '0;
      act_ins   <= s1_valid ? cur_ins : '0;
      act_count <= s1_valid ? u_count : '0;
    end
  end

  // R3: a list-mode record's count agrees with its occupied slots
  p_list_bound_r3: assert property (@(posedge clk) disable iff (rst)
    (s1_valid && !cur_mode) |-> ($countones(cur_vld) == int'(cur_count)));

  // R10: a counter-mode record never holds zero copies
  p_cnt_nonzero_r10: assert property (@(posedge clk) disable iff (rst)
    (s1_valid && cur_mode) |-> (cur_count != '0));

  // R6: a targeted update names at least one target and reports their number
  p_update_nonempty_r6: assert property (@(posedge clk) disable iff (rst)
    (act_valid && act_code == ACT_MUPD) |->
      (act_mask != '0 && int'(act_count) == $countones(act_mask)));

  // R8: a broadcast carries a count and no slot mask
  p_bcast_count_r8: assert property (@(posedge clk) disable iff (rst)
    (act_valid && act_code == ACT_BCAST) |-> (act_count != '0 && act_mask == '0));

  // R2: no action code outside a result strobe
  p_idle_quiet_r2: assert property (@(posedge clk) disable iff (rst)
    !act_valid |-> (act_code == ACT_NONE && act_mask == '0));

  // R7: an eviction always leaves an empty record behind
  p_inval_clears_r7: assert property (@(posedge clk) disable iff (rst)
    (s1_valid && s1_op == OP_EVICT) |=> (wb_rec == '0));
endmodule

// File: tb/coh_directory_tb.sv
module coh_directory_tb;
  localparam int LINE_W = 4;
  localparam int SRC_W  = 4;
  localparam int THRESH = 4;

  logic                    clk = 1'b0;
  logic                    rst = 1'b1;
  logic                    req_valid = 1'b0;
  logic [1:0]              req_op = '0;
  logic [LINE_W-1:0]       req_line = '0;
  logic [SRC_W-1:0]        req_src = '0;
  logic                    req_ins = 1'b0;
  logic                    act_valid;
  logic [1:0]              act_code;
  logic [THRESH-1:0]       act_mask;
  logic [THRESH*SRC_W-1:0] act_src;
  logic [THRESH-1:0]       act_ins;
  logic [SRC_W+1:0]        act_count;

  int n_chk = 0;
  int n_bad = 0;
  bit done  = 0;

  // captured result of the last request
  logic [1:0]              c_code;
  logic [THRESH-1:0]       c_mask;
  logic [THRESH*SRC_W-1:0] c_src;
  logic [THRESH-1:0]       c_ins;
  logic [SRC_W+1:0]        c_count;
  logic                    c_valid;

  always #2 clk = ~clk;

  coh_directory #(.LINE_W(LINE_W), .SRC_W(SRC_W), .THRESH(THRESH)) u_dut (
    .clk(clk), .rst(rst), .req_valid(req_valid), .req_op(req_op),
    .req_line(req_line), .req_src(req_src), .req_ins(req_ins),
    .act_valid(act_valid), .act_code(act_code), .act_mask(act_mask),
    .act_src(act_src), .act_ins(act_ins), .act_count(act_count)
  );

  task automatic chk(string tag, int actual, int expected);
    n_chk++;
    if (actual != expected) begin
      n_bad++;
      $display("FAIL %s: actual %0d expected %0d", tag, actual, expected);
    end
  endtask

  task automatic capture();
    c_valid = act_valid;
    c_code  = act_code;
    c_mask  = act_mask;
    c_src   = act_src;
    c_ins   = act_ins;
    c_count = act_count;
  endtask

  task automatic send(input logic [1:0] op, input int line, input int src, input logic ins);
    @(negedge clk);
    req_valid = 1'b1; req_op = op;
    req_line = LINE_W'(line); req_src = SRC_W'(src); req_ins = ins;
    @(posedge clk);
    @(negedge clk);
    req_valid = 1'b0;
    @(posedge clk);
    #1 capture();
  endtask

  task automatic t_reset();
    @(negedge clk);
    chk("R1 act_valid after reset", act_valid, 0);
    send(2'd3, 5, 0, 1'b0);
    chk("R2 strobe on result", c_valid, 1);
    chk("R1 fresh evict code", c_code, 0);
    chk("R1 fresh evict mask", c_mask, 0);
    chk("R1 fresh evict count", c_count, 0);
    @(posedge clk); #1;
    chk("R2 strobe one cycle", act_valid, 0);
    chk("R2 idle code NONE", act_code, 0);
  endtask

  task automatic t_types_dup();
    send(2'd0, 1, 3, 1'b0);
    send(2'd0, 1, 3, 1'b1);
    send(2'd0, 1, 3, 1'b0);
    send(2'd3, 1, 0, 1'b0);
    chk("R7 evict list code", c_code, 2);
    chk("R4 duplicate ignored count", c_count, 2);
    chk("R3 two-type mask", c_mask, 4'b0011);
    chk("R3 slot sources", c_src[7:0], 8'h33);
    chk("R3 slot types", c_ins, 4'b0010);
    send(2'd3, 1, 0, 1'b0);
    chk("R7 line empty after inval", c_code, 0);
  endtask

  task automatic t_write_update();
    send(2'd0, 2, 1, 1'b0);
    send(2'd0, 2, 2, 1'b0);
    send(2'd0, 2, 5, 1'b1);
    send(2'd2, 2, 1, 1'b0);
    chk("R6 update code", c_code, 1);
    chk("R6 writer excluded mask", c_mask, 4'b0110);
    chk("R6 target count", c_count, 2);
    send(2'd2, 2, 1, 1'b0);
    chk("R6 record unchanged mask", c_mask, 4'b0110);
    send(2'd0, 3, 4, 1'b0);
    send(2'd2, 3, 4, 1'b0);
    chk("R6 sole writer no action", c_code, 0);
  endtask

  task automatic t_overflow();
    for (int s = 1; s <= 4; s++) send(2'd0, 4, s, 1'b0);
    send(2'd2, 4, 1, 1'b0);
    chk("R6 at threshold still update", c_code, 1);
    chk("R6 at threshold mask", c_mask, 4'b1110);
    send(2'd0, 4, 5, 1'b0);
    send(2'd2, 4, 1, 1'b0);
    chk("R5 overflow write broadcast", c_code, 3);
    chk("R5 overflow count", c_count, THRESH + 1);
    send(2'd3, 4, 0, 1'b0);
    chk("R8 cleared after broadcast", c_code, 0);
    for (int s = 1; s <= 6; s++) send(2'd0, 6, s, 1'b0);
    send(2'd3, 6, 0, 1'b0);
    chk("R8 evict broadcast code", c_code, 3);
    chk("R5 count increments in counter mode", c_count, 6);
    chk("R8 broadcast mask zero", c_mask, 0);
    send(2'd3, 6, 0, 1'b0);
    chk("R8 line empty after evict", c_code, 0);
  endtask

  task automatic t_cleanup();
    send(2'd0, 7, 1, 1'b0);
    send(2'd0, 7, 2, 1'b0);
    send(2'd1, 7, 9, 1'b0);
    send(2'd1, 7, 1, 1'b1);
    send(2'd3, 7, 0, 1'b0);
    chk("R9 unmatched cleanup mask", c_mask, 4'b0011);
    chk("R9 unmatched cleanup count", c_count, 2);
    send(2'd0, 7, 1, 1'b0);
    send(2'd0, 7, 2, 1'b0);
    send(2'd1, 7, 1, 1'b0);
    send(2'd3, 7, 0, 1'b0);
    chk("R9 matched slot freed", c_mask, 4'b0010);
    chk("R9 count after cleanup", c_count, 1);
  endtask

  task automatic t_counter_cleanup();
    for (int s = 1; s <= 5; s++) send(2'd0, 8, s, 1'b0);
    for (int k = 0; k < 3; k++) send(2'd1, 8, k, 1'b0);
    send(2'd2, 8, 1, 1'b0);
    chk("R10 stays counter mode", c_code, 3);
    chk("R10 decremented count", c_count, 2);
    for (int s = 1; s <= 5; s++) send(2'd0, 9, s, 1'b0);
    for (int k = 0; k < 5; k++) send(2'd1, 9, k, 1'b0);
    send(2'd0, 9, 7, 1'b0);
    send(2'd3, 9, 0, 1'b0);
    chk("R10 back to list mode code", c_code, 2);
    chk("R10 back to list mode mask", c_mask, 4'b0001);
    chk("R10 back to list mode src", c_src[3:0], 7);
  endtask

  task automatic t_back_to_back();
    @(negedge clk);
    req_valid = 1'b1; req_line = 4'd10; req_op = 2'd0; req_src = 4'd2; req_ins = 1'b0;
    @(negedge clk);
    req_src = 4'd3;
    @(negedge clk);
    req_op = 2'd3; req_src = 4'd0;
    @(negedge clk);
    req_valid = 1'b0;
    chk("R11 strobe stays high", act_valid, 1);
    @(posedge clk); #1;
    chk("R11 chained evict code", act_code, 2);
    chk("R11 chained evict mask", act_mask, 4'b0011);
    chk("R11 chained evict count", act_count, 2);
    chk("R11 chained sources", act_src[7:0], 8'h32);
  endtask

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk) rst = 1'b0;
    t_reset();
    t_types_dup();
    t_write_update();
    t_overflow();
    t_cleanup();
    t_counter_cleanup();
    t_back_to_back();
    if (!done) begin
      done = 1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    #(4 * 200000);
    if (!done) begin
      done = 1;
      n_chk++;
      n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end
endmodule